// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Divider and Dual-Command Clear

This block guards a small microcontroller core against runaway software. It counts ticks from one of two sources picked by a static strap. One source is a free-running RC oscillator tick. The other is the instruction-clock tick, which is the system clock divided by four. The ticks go first through a fixed 256-step divider and then through a prescaler whose ratio is 2^WS. WS is held in the low three bits of an 8-bit control register. The other five bits of that register are spare flags for software.

Software restarts the count with decoded clear strobes. An optional strap makes the clear two-phase: two distinct commands must both arrive before the restart happens. Entering HALT and the external active-low reset also restart the count. If the count runs out while the core is running, the block emits a one-cycle full chip reset and sets a time-out flag. If it runs out during HALT, the block emits only a one-cycle warm reset, meant for the program counter and stack pointer. All logic runs on one free-running clock, and both tick sources arrive as single-cycle enables.

Top module: `wdt_guard`

## Requirements
- R1: While and after the external reset, both reset pulses are low, the time-out flag is 0, the count is zero, and the control register reads 8'h07.
- R2: With the block enabled, a time-out occurs on exactly the 256*2^WS-th counted tick after the count was zeroed, where WS = control bits 2:0 (000 gives 1:1, 111 gives 1:128). The reset pulse is visible in the cycle after the posedge that took the final tick, and it lasts exactly one cycle.
- R3: Control bits 7:3 read back as written and have no effect on timing.
- R4: When cfgUseRc is 1, only rcTick advances the count. When cfgUseRc is 0, only instrTick advances it.
- R5: When the instruction tick is the source, the count holds while haltMode is 1. When the RC tick is the source, counting continues during HALT.
- R6: A time-out while haltMode is 1 pulses warmResetPulse and not chipResetPulse, and it leaves the time-out flag unchanged.
- R7: A time-out while haltMode is 0 pulses chipResetPulse and sets toFlag. The flag stays set until it is cleared.
- R8: In single-clear mode (cfgDualClr=0), one clrSingle strobe zeroes the count. In this mode clr1 and clr2 have no effect.
- R9: In dual-clear mode, the count is zeroed only once both clr1 and clr2 have arrived, in either order. A repeated clr1 alone or clr2 alone does nothing, and clrSingle is ignored.
- R10: A haltEntry strobe zeroes the count in either clear mode.
- R11: A completed software clear drops toFlag. A haltEntry strobe does not.
- R12: With cfgEnable at 0, no time-out ever occurs, and clear strobes are not recorded.
- R13: A clear in the same cycle as the final tick wins. No pulse is produced, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | External reset, active low, asynchronous |
| cfgEnable | input | 1 | Static strap: watchdog enabled |
| cfgUseRc | input | 1 | Static strap: 1 = RC tick source, 0 = instruction tick |
| cfgDualClr | input | 1 | Static strap: 1 = two-command clear |
| rcTick | input | 1 | RC oscillator tick enable |
| instrTick | input | 1 | Instruction clock tick enable |
| haltMode | input | 1 | Core is in HALT |
| haltEntry | input | 1 | Strobe: HALT being entered |
| clrSingle | input | 1 | Strobe: single-command clear |
| clr1 | input | 1 | Strobe: first of the two clear commands |
| clr2 | input | 1 | Strobe: second of the two clear commands |
| ctrlWe | input | 1 | Control register write enable |
| ctrlWdata | input | 8 | Control register write data |
| ctrlRdata | output | 8 | Control register contents |
| chipResetPulse | output | 1 | One-cycle full chip reset |
| warmResetPulse | output | 1 | One-cycle program counter and stack reset |
| toFlag | output | 1 | Time-out status |

## Verification
A software clear and the tick that completes the count can arrive in the same cycle. The bench provokes this by running the count to one tick short of the limit, then driving the last tick and clrSingle together. The collision is judged correct if no pulse appears and a full 256*2^WS ticks are then needed for the next time-out. A second collision is the completion of a two-phase clear against a flag that is already set. The bench checks that the completed clear drops toFlag, while a haltEntry in the same position leaves the flag set.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  typedef struct packed {
    logic tick;
    logic clear;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_guard_count.sv
module wdt_guard_count
  import wdt_guard_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int WS_W  = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  wdtStrobe_t      strobe,
  input  logic [WS_W-1:0] ws,
  output logic            ovfNow
);
  localparam int PRE_W = (1 << WS_W) - 1;

  logic [DIV_W-1:0] divCnt;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   limitWide;
  logic [PRE_W-1:0] limit;
  logic             divWrap;
  logic             preDone;

  always_comb begin
    limitWide = ({{PRE_W{1'b0}}, 1'b1} << ws) - 1'b1;
    limit     = limitWide[PRE_W-1:0];
    divWrap   = strobe.tick && (&divCnt);
    preDone   = (preCnt >= limit);
    ovfNow    = divWrap && preDone && !strobe.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      preCnt <= '0;
    end else if (strobe.clear) begin
      divCnt <= '0;
      preCnt <= '0;
    end else if (strobe.tick) begin
      divCnt <= divCnt + 1'b1;
      if (divWrap) preCnt <= preDone ? '0 : preCnt + 1'b1;
    end
  end

  // R13
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (divCnt == '0 && preCnt == '0));
  // R2
  div_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.clear) |=> (divCnt == $past(divCnt) + 1'b1));
  // R2
  ovf_at_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfNow |-> (divCnt == {DIV_W{1'b1}}));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.clear) |=> $stable(divCnt));
endmodule

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int              CTRL_W   = 8,
  parameter int              WS_W     = 3,
  parameter logic [CTRL_W-1:0] CTRL_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgUseRc,
  input  logic              cfgDualClr,
  input  logic              rcTick,
  input  logic              instrTick,
  input  logic              haltMode,
  input  logic              haltEntry,
  input  logic              clrSingle,
  input  logic              clr1,
  input  logic              clr2,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  output logic [WS_W-1:0]   ws,
  output wdtStrobe_t        strobe,
  input  logic              ovfNow,
  output logic              chipResetPulse,
  output logic              warmResetPulse,
  output logic              toFlag
);
  logic [CTRL_W-1:0] ctrlReg;
  logic pend1, pend2;
  logic srcTick, swDone;

  always_comb begin
    srcTick = cfgUseRc ? rcTick : (instrTick && !haltMode);
    if (cfgDualClr) swDone = (pend1 || clr1) && (pend2 || clr2);
    else            swDone = clrSingle;
    swDone       = swDone && cfgEnable;
    strobe.tick  = cfgEnable && srcTick;
    strobe.clear = swDone || (cfgEnable && haltEntry);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend1 <= 1'b0;
      pend2 <= 1'b0;
    end else if (!cfgDualClr || swDone) begin
      pend1 <= 1'b0;
      pend2 <= 1'b0;
    end else if (cfgEnable) begin
      pend1 <= pend1 || clr1;
      pend2 <= pend2 || clr2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg        <= CTRL_RST;
      chipResetPulse <= 1'b0;
      warmResetPulse <= 1'b0;
      toFlag         <= 1'b0;
    end else begin
      if (ctrlWe) ctrlReg <= ctrlWdata;
      chipResetPulse <= ovfNow && !haltMode;
      warmResetPulse <= ovfNow && haltMode;
      if (swDone)                     toFlag <= 1'b0;
      else if (ovfNow && !haltMode)   toFlag <= 1'b1;
    end
  end

  assign ctrlRdata = ctrlReg;
  assign ws        = ctrlReg[WS_W-1:0];

  // R6
  warm_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    warmResetPulse |-> $past(haltMode));
  // R7
  to_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> chipResetPulse);
  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (!chipResetPulse && !warmResetPulse));
  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipResetPulse |=> !chipResetPulse);
  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({chipResetPulse, warmResetPulse}));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WS_W   = 3,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgUseRc,
  input  logic              cfgDualClr,
  input  logic              rcTick,
  input  logic              instrTick,
  input  logic              haltMode,
  input  logic              haltEntry,
  input  logic              clrSingle,
  input  logic              clr1,
  input  logic              clr2,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  output logic              chipResetPulse,
  output logic              warmResetPulse,
  output logic              toFlag
);
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'((1 << WS_W) - 1);

  wdtStrobe_t      strobe;
  logic [WS_W-1:0] ws;
  logic            ovfNow;

  wdt_guard_ctrl #(.CTRL_W(CTRL_W), .WS_W(WS_W), .CTRL_RST(CTRL_RST)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgUseRc(cfgUseRc),
    .cfgDualClr(cfgDualClr), .rcTick(rcTick), .instrTick(instrTick),
    .haltMode(haltMode), .haltEntry(haltEntry), .clrSingle(clrSingle),
    .clr1(clr1), .clr2(clr2), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .ws(ws), .strobe(strobe), .ovfNow(ovfNow),
    .chipResetPulse(chipResetPulse), .warmResetPulse(warmResetPulse),
    .toFlag(toFlag)
  );

  wdt_guard_count #(.DIV_W(DIV_W), .WS_W(WS_W)) uCount (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ws(ws), .ovfNow(ovfNow)
  );
endmodule

// File: tb/tb_wdt_guard.sv
`timescale 1ns/1ps
module tb_wdt_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b1, cfgUseRc = 1'b1, cfgDualClr = 1'b0;
  logic rcTick = 1'b0, instrTick = 1'b0, haltMode = 1'b0, haltEntry = 1'b0;
  logic clrSingle = 1'b0, clr1 = 1'b0, clr2 = 1'b0, ctrlWe = 1'b0;
  logic [7:0] ctrlWdata = 8'h00;
  logic [7:0] ctrlRdata;
  logic chipResetPulse, warmResetPulse, toFlag;

  int tests = 0, fails = 0, chipCnt = 0, warmCnt = 0;

  always #5 clk = ~clk;

  wdt_guard dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgUseRc(cfgUseRc),
    .cfgDualClr(cfgDualClr), .rcTick(rcTick), .instrTick(instrTick),
    .haltMode(haltMode), .haltEntry(haltEntry), .clrSingle(clrSingle),
    .clr1(clr1), .clr2(clr2), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .chipResetPulse(chipResetPulse),
    .warmResetPulse(warmResetPulse), .toFlag(toFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    if (chipResetPulse) chipCnt++;
    if (warmResetPulse) warmCnt++;
  endtask

  task automatic doReset(input logic en, input logic rc, input logic dual);
    cfgEnable = en; cfgUseRc = rc; cfgDualClr = dual;
    rcTick = 0; instrTick = 0; haltMode = 0; haltEntry = 0;
    clrSingle = 0; clr1 = 0; clr2 = 0; ctrlWe = 0;
    rstN = 0;
    cyc(); cyc();
    rstN = 1;
    cyc();
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    ctrlWe = 1; ctrlWdata = v;
    cyc();
    ctrlWe = 0;
  endtask

  task automatic tickN(input int n, input bit useInstr);
    for (int i = 0; i < n; i++) begin
      if (useInstr) instrTick = 1; else rcTick = 1;
      cyc();
    end
    rcTick = 0; instrTick = 0;
  endtask

  // kind: 0 single, 1 clr1, 2 clr2, 3 halt entry
  task automatic doClr(input int kind);
    clrSingle = (kind == 0); clr1 = (kind == 1);
    clr2 = (kind == 2); haltEntry = (kind == 3);
    cyc();
    clrSingle = 0; clr1 = 0; clr2 = 0; haltEntry = 0;
  endtask

  task automatic expectTimeout(input string req, input int already);
    int c0;
    c0 = chipCnt;
    tickN(255 - already, 0);
    chk({req, " no pulse before limit"}, chipCnt - c0, 0);
    tickN(1, 0);
    chk({req, " pulse at limit"}, chipCnt - c0, 1);
  endtask

  initial begin
    #(190000 * 10);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c0, w0;
    // R1 reset state
    cfgEnable = 1; cfgUseRc = 1;
    cyc();
    chk("R1 chip low in reset", chipResetPulse, 0);
    doReset(1, 1, 0);
    chk("R1 ctrl reset value", ctrlRdata, 8'h07);
    chk("R1 chip low", chipResetPulse, 0);
    chk("R1 warm low", warmResetPulse, 0);
    chk("R1 toFlag low", toFlag, 0);

    // R2 / R7 sweep of every prescaler code
    for (int w = 0; w < 8; w++) begin
      doReset(1, 1, 0);
      writeCtrl(8'(w));
      c0 = chipCnt;
      tickN(256 * (1 << w) - 1, 0);
      chk($sformatf("R2 ws=%0d early", w), chipCnt - c0, 0);
      chk("R7 flag clear before time-out", toFlag, 0);
      tickN(1, 0);
      chk($sformatf("R2 ws=%0d pulse", w), chipResetPulse, 1);
      chk("R7 flag set", toFlag, 1);
      cyc();
      chk("R2 pulse one cycle", chipResetPulse, 0);
      tickN(10, 0);
      chk("R7 flag sticky", toFlag, 1);
    end

    // R3 spare flags
    doReset(1, 1, 0);
    writeCtrl(8'hA8);
    chk("R3 readback", ctrlRdata, 8'hA8);
    expectTimeout("R3 flags no timing effect", 0);
    writeCtrl(8'hF8);
    chk("R3 readback all flags", ctrlRdata, 8'hF8);

    // R4 source select
    doReset(1, 1, 0); writeCtrl(8'h00);
    c0 = chipCnt;
    tickN(300, 1);
    chk("R4 instr ignored with rc source", chipCnt - c0, 0);
    expectTimeout("R4 rc counts", 0);
    doReset(1, 0, 0); writeCtrl(8'h00);
    c0 = chipCnt;
    tickN(300, 0);
    chk("R4 rc ignored with instr source", chipCnt - c0, 0);
    tickN(255, 1);
    chk("R4 instr early", chipCnt - c0, 0);
    tickN(1, 1);
    chk("R4 instr counts", chipCnt - c0, 1);

    // R5 instruction source stops in HALT
    doReset(1, 0, 0); writeCtrl(8'h00);
    haltMode = 1;
    c0 = chipCnt; w0 = warmCnt;
    tickN(300, 1);
    chk("R5 halted instr chip", chipCnt - c0, 0);
    chk("R5 halted instr warm", warmCnt - w0, 0);
    haltMode = 0;
    tickN(255, 1);
    chk("R5 resumed early", chipCnt - c0, 0);
    tickN(1, 1);
    chk("R5 resumed timeout", chipCnt - c0, 1);

    // R5 / R6 RC source keeps counting in HALT, warm reset only
    doReset(1, 1, 0); writeCtrl(8'h00);
    haltMode = 1;
    c0 = chipCnt; w0 = warmCnt;
    tickN(256, 0);
    chk("R5 rc counts in halt", warmCnt - w0, 1);
    chk("R6 no chip pulse in halt", chipCnt - c0, 0);
    chk("R6 toFlag untouched", toFlag, 0);
    haltMode = 0;

    // R8 single clear
    doReset(1, 1, 0); writeCtrl(8'h00);
    tickN(200, 0);
    doClr(0);
    expectTimeout("R8 single clear restarts", 0);
    doReset(1, 1, 0); writeCtrl(8'h00);
    tickN(200, 0);
    doClr(1); doClr(2);
    expectTimeout("R8 clr1 clr2 ignored in single mode", 200);

    // R9 dual clear
    doReset(1, 1, 1); writeCtrl(8'h00);
    tickN(200, 0);
    doClr(1); doClr(1);
    expectTimeout("R9 repeated clr1 no clear", 200);
    doReset(1, 1, 1); writeCtrl(8'h00);
    tickN(200, 0);
    doClr(0);
    expectTimeout("R9 clrSingle ignored in dual", 200);
    doReset(1, 1, 1); writeCtrl(8'h00);
    tickN(100, 0);
    doClr(2);
    tickN(10, 0);
    doClr(1);
    expectTimeout("R9 clr2 then clr1 clears", 0);
    doReset(1, 1, 1); writeCtrl(8'h00);
    tickN(100, 0);
    doClr(1);
    tickN(10, 0);
    doClr(2);
    expectTimeout("R9 clr1 then clr2 clears", 0);

    // R10 halt entry clears in both modes
    doReset(1, 1, 1); writeCtrl(8'h00);
    tickN(200, 0);
    doClr(3);
    expectTimeout("R10 halt entry dual mode", 0);
    doReset(1, 1, 0); writeCtrl(8'h00);
    tickN(200, 0);
    doClr(3);
    expectTimeout("R10 halt entry single mode", 0);

    // R11 flag cleared by software clear only
    doReset(1, 1, 1); writeCtrl(8'h00);
    tickN(256, 0);
    chk("R11 flag set", toFlag, 1);
    doClr(3);
    chk("R11 halt entry keeps flag", toFlag, 1);
    doClr(1);
    chk("R11 half dual clear keeps flag", toFlag, 1);
    doClr(2);
    chk("R11 completed clear drops flag", toFlag, 0);

    // R12 global disable
    doReset(0, 1, 0); writeCtrl(8'h00);
    c0 = chipCnt;
    tickN(1000, 0);
    chk("R12 no timeout when disabled", chipCnt - c0, 0);
    chk("R12 flag stays low", toFlag, 0);
    doReset(1, 1, 1); writeCtrl(8'h00);
    tickN(200, 0);
    cfgEnable = 0;
    doClr(1);
    cfgEnable = 1;
    doClr(2);
    expectTimeout("R12 clr1 while disabled not recorded", 200);

    // R13 clear on the final tick wins
    doReset(1, 1, 0); writeCtrl(8'h00);
    tickN(255, 0);
    c0 = chipCnt;
    rcTick = 1; clrSingle = 1;
    cyc();
    rcTick = 0; clrSingle = 0;
    cyc();
    chk("R13 no pulse on collision", chipCnt - c0, 0);
    expectTimeout("R13 full period after collision", 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule